// File: doc/BRIEF.md
# Interval Timer Peripheral

This block is a 32-bit down-counting interval timer that software reaches through a small word-addressed register bus. Software loads a 32-bit period as two 16-bit halves. It selects one-shot or continuous operation, starts and stops the count with write-only strobes, and can freeze a copy of the live count into two readable snapshot halves. Each expiry sets a timeout flag. A level interrupt follows that flag while the interrupt enable is set.

The counter moves only on cycles where the external `tick_en` input is high. A prescaler outside the block can therefore set the count rate. The bus has a write strobe, a byte address whose two low bits are ignored, and write data. Read data is a combinational function of the address and the register state.

Top module: `interval_timer`

## Requirements
- R1: After reset, status, control, both period halves and both snapshot halves read zero, `irq` is low, the timer is stopped, and the count is 0xFFFF_FFFF, so a snapshot taken at once reads 0xFFFF in both halves.
- R2: The word index is the byte address shifted right by two. Index 0 is status, 1 is control, 2 is period low, 3 is period high, 4 is snapshot low and 5 is snapshot high. Any other index reads zero, and a write to it changes no state.
- R3: Control bit 0 is the interrupt enable and bit 1 selects continuous mode. These two bits are stored, and a control read returns them in bits 1:0. Control bits 2 and 3 are strobes and always read back as zero.
- R4: A control write with bit 2 set starts a stopped timer, and status bit 1 (running) then reads 1. A control write with bit 3 set stops the timer. When both bits are set in one write, the timer ends up stopped.
- R5: While the timer runs, the count drops by one on each cycle with `tick_en` high. Without a tick, or while the timer is stopped, the count holds.
- R6: A tick at count zero is an expiry. It sets status bit 0 (timeout) and reloads the count with the period {high, low}. An interval that starts from the period value therefore lasts period+1 ticks.
- R7: At expiry in one-shot mode, the running flag clears and the count stays at the period. In continuous mode, the timer keeps running from the reloaded count.
- R8: A write to either period half stores data bits 15:0, stops the timer, and loads the count with the new combined period. Counting does not happen in that cycle.
- R9: A write to either snapshot address copies the count held in that cycle into the snapshot halves: bits 15:0 go to the low half and bits 31:16 to the high half. Each half reads back zero-extended.
- R10: Any write to status clears the timeout flag, whatever the data. If an expiry happens in the same cycle, the flag stays set.
- R11: `irq` is high exactly while the timeout flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one cycle per tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address (ADDR_W) |
| bus_wdata | input | 32 | Write data (DATA_W) |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the collisions inside a single cycle. One is a status clear that lands on the same tick as an expiry. Another is a start and a stop strobe carried in the same control write. A third is a period write while the counter is mid-interval in continuous mode. The stimulus sets the period to one, starts the timer in continuous mode, and spends one tick to reach count zero. It then issues the status write with `tick_en` high, so the clear and the expiry coincide. A reference model advanced on every clock checks the interrupt and the addressed read value after each step. Every count value the stimulus relies on is read back through the snapshot registers.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // word indices of the register file
    localparam int IDX_STATUS  = 0;
    localparam int IDX_CTRL    = 1;
    localparam int IDX_PER_LO  = 2;
    localparam int IDX_PER_HI  = 3;
    localparam int IDX_SNAP_LO = 4;
    localparam int IDX_SNAP_HI = 5;

    // control and status bit positions
    localparam int BIT_IE    = 0;
    localparam int BIT_CONT  = 1;
    localparam int BIT_START = 2;
    localparam int BIT_STOP  = 3;
    localparam int BIT_TO    = 0;
    localparam int BIT_RUN   = 1;
    localparam int CTL_BITS  = 4;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_CTRL    = 3'd1,
        SEL_PER_LO  = 3'd2,
        SEL_PER_HI  = 3'd3,
        SEL_SNAP_LO = 3'd4,
        SEL_SNAP_HI = 3'd5,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    // one decoded bus write
    typedef struct packed {
        logic wr_status;
        logic wr_ctrl;
        logic wr_per_lo;
        logic wr_per_hi;
        logic wr_snap;
        logic ie;
        logic cont;
        logic start;
        logic stop;
    } bus_cmd_t;

    // control state of the timer
    typedef struct packed {
        logic to;
        logic run;
        logic ie;
        logic cont;
    } ctl_state_t;

    function automatic reg_sel_e decode_sel(input int unsigned idx);
        case (idx)
            IDX_STATUS:  return SEL_STATUS;
            IDX_CTRL:    return SEL_CTRL;
            IDX_PER_LO:  return SEL_PER_LO;
            IDX_PER_HI:  return SEL_PER_HI;
            IDX_SNAP_LO: return SEL_SNAP_LO;
            IDX_SNAP_HI: return SEL_SNAP_HI;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]    word_idx,
    input  logic                bus_wr,
    input  logic [CTL_BITS-1:0] ctl_bits,
    output reg_sel_e            sel,
    output bus_cmd_t            cmd
);

    always_comb begin
        sel           = decode_sel(32'(word_idx));
        cmd.wr_status = bus_wr && (sel == SEL_STATUS);
        cmd.wr_ctrl   = bus_wr && (sel == SEL_CTRL);
        cmd.wr_per_lo = bus_wr && (sel == SEL_PER_LO);
        cmd.wr_per_hi = bus_wr && (sel == SEL_PER_HI);
        cmd.wr_snap   = bus_wr && ((sel == SEL_SNAP_LO) || (sel == SEL_SNAP_HI));
        cmd.ie        = ctl_bits[BIT_IE];
        cmd.cont      = ctl_bits[BIT_CONT];
        cmd.start     = ctl_bits[BIT_START];
        cmd.stop      = ctl_bits[BIT_STOP];
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = run && tick && at_zero && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (load) begin
            count <= load_val;
        end else if (run && tick) begin
            count <= at_zero ? reload_val : count - 1'b1;
        end
    end

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int DATA_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  bus_cmd_t          cmd,
    input  logic [HALF_W-1:0] wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    output ctl_state_t        st,
    output logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  load_val,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctl_state_t        st_d;
    logic [HALF_W-1:0] per_lo_q, per_hi_q, per_lo_d, per_hi_d;
    logic [HALF_W-1:0] snap_lo_q, snap_hi_q;

    always_comb begin
        st_d = st;
        // timeout: clear on status write, expiry wins a collision
        if (cmd.wr_status) st_d.to = 1'b0;
        if (expire)        st_d.to = 1'b1;
        if (expire && !st.cont) st_d.run = 1'b0;
        if (cmd.wr_ctrl) begin
            st_d.ie   = cmd.ie;
            st_d.cont = cmd.cont;
            if (cmd.start && !st.run) st_d.run = 1'b1;
            if (cmd.stop)             st_d.run = 1'b0;
        end
        per_lo_d = cmd.wr_per_lo ? wdata : per_lo_q;
        per_hi_d = cmd.wr_per_hi ? wdata : per_hi_q;
        if (cmd.wr_per_lo || cmd.wr_per_hi) st_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            per_lo_q  <= '0;
            per_hi_q  <= '0;
            snap_lo_q <= '0;
            snap_hi_q <= '0;
        end else begin
            st       <= st_d;
            per_lo_q <= per_lo_d;
            per_hi_q <= per_hi_d;
            if (cmd.wr_snap) begin
                snap_lo_q <= count[HALF_W-1:0];
                snap_hi_q <= count[CNT_W-1:HALF_W];
            end
        end
    end

    assign period   = {per_hi_q, per_lo_q};
    assign load_val = {per_hi_d, per_lo_d};
    assign irq      = st.to && st.ie;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: begin
                rdata[BIT_TO]  = st.to;
                rdata[BIT_RUN] = st.run;
            end
            SEL_CTRL: begin
                rdata[BIT_IE]   = st.ie;
                rdata[BIT_CONT] = st.cont;
            end
            SEL_PER_LO:  rdata[HALF_W-1:0] = per_lo_q;
            SEL_PER_HI:  rdata[HALF_W-1:0] = per_hi_q;
            SEL_SNAP_LO: rdata[HALF_W-1:0] = snap_lo_q;
            SEL_SNAP_HI: rdata[HALF_W-1:0] = snap_hi_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * HALF_W;
    localparam int IDX_W = ADDR_W - 2;

    reg_sel_e         sel;
    bus_cmd_t         cmd;
    ctl_state_t       st;
    logic             run, to_flag, cont, expire;
    logic [CNT_W-1:0] count, period, load_val;
    logic             unused_bits;

    // byte lane bits and data above the half width carry no meaning
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:HALF_W]};

    ivt_decode #(.IDX_W(IDX_W)) u_decode (
        .word_idx (bus_addr[ADDR_W-1:2]),
        .bus_wr   (bus_wr),
        .ctl_bits (bus_wdata[CTL_BITS-1:0]),
        .sel      (sel),
        .cmd      (cmd)
    );

    ivt_regs #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .cmd      (cmd),
        .wdata    (bus_wdata[HALF_W-1:0]),
        .expire   (expire),
        .count    (count),
        .st       (st),
        .period   (period),
        .load_val (load_val),
        .rdata    (bus_rdata),
        .irq      (irq)
    );

    assign run     = st.run;
    assign to_flag = st.to;
    assign cont    = st.cont;

    ivt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (tick_en),
        .load       (cmd.wr_per_lo || cmd.wr_per_hi),
        .load_val   (load_val),
        .reload_val (period),
        .count      (count),
        .expire     (expire)
    );

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input bus_cmd_t         cmd,
    input logic             run,
    input logic             to_flag,
    input logic             cont,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             expire
);

    logic per_wr;
    assign per_wr = cmd.wr_per_lo || cmd.wr_per_hi;

    // R4
    start_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(cmd.wr_ctrl && cmd.start && !cmd.stop));

    // R8
    period_stop_chk: assert property (@(posedge clk) disable iff (rst)
        per_wr |=> !run);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !per_wr) |=> $stable(count));

    // R6
    timeout_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> $past(run && tick_en));

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && !cont) |=> (!run && count == $past(period)));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_status && !expire) |=> !to_flag);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(cmd.wr_status || cmd.wr_ctrl));

endmodule

bind interval_timer ivt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .cmd     (cmd),
    .run     (run),
    .to_flag (to_flag),
    .cont    (cont),
    .irq     (irq),
    .count   (count),
    .period  (period),
    .expire  (expire)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // reference model state
    bit        m_to, m_run, m_ie, m_cont;
    bit [15:0] m_plo, m_phi, m_slo, m_shi;
    bit [31:0] m_cnt = 32'hFFFF_FFFF;

    interval_timer u_interval_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [7:0] a);
        case (a >> 2)
            0: return "R10";
            1: return "R3";
            2, 3: return "R8";
            4, 5: return "R9";
            default: return "R2";
        endcase
    endfunction

    function automatic bit [31:0] m_read(input logic [7:0] a);
        case (a >> 2)
            0: return {30'd0, m_run, m_to};
            1: return {30'd0, m_cont, m_ie};
            2: return {16'd0, m_plo};
            3: return {16'd0, m_phi};
            4: return {16'd0, m_slo};
            5: return {16'd0, m_shi};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
        int idx = int'(a >> 2);
        bit wp = w && (idx == 2 || idx == 3);
        bit ev = m_run && t && (m_cnt == 0) && !wp;
        bit n_to = m_to, n_run = m_run, n_ie = m_ie, n_cont = m_cont;
        bit [15:0] nlo = m_plo, nhi = m_phi;
        bit [31:0] n_cnt = m_cnt;
        if (w && idx == 0) n_to = 1'b0;
        if (ev) n_to = 1'b1;
        if (ev && !m_cont) n_run = 1'b0;
        if (w && idx == 1) begin
            n_ie = d[0];
            n_cont = d[1];
            if (d[2] && !m_run) n_run = 1'b1;
            if (d[3]) n_run = 1'b0;
        end
        if (w && idx == 2) nlo = d[15:0];
        if (w && idx == 3) nhi = d[15:0];
        if (wp) begin
            n_run = 1'b0;
            n_cnt = {nhi, nlo};
        end else if (m_run && t) begin
            n_cnt = (m_cnt == 0) ? {m_phi, m_plo} : m_cnt - 1;
        end
        if (w && (idx == 4 || idx == 5)) begin
            m_slo = m_cnt[15:0];
            m_shi = m_cnt[31:16];
        end
        m_to = n_to; m_run = n_run; m_ie = n_ie; m_cont = n_cont;
        m_plo = nlo; m_phi = nhi; m_cnt = n_cnt;
    endtask

    // one clock: drive, advance model, compare irq and the addressed read
    task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d, input bit t);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
        @(posedge clk);
        model_step(w, a, d, t);
        #1;
        chk("R11 irq", {31'd0, irq}, {31'd0, m_irq()});
        chk(req_of(a), bus_rdata, m_read(a));
    endtask

    function automatic bit m_irq();
        return m_to && m_ie;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'd0, 1'b1);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        step(1'b0, a, 32'd0, 1'b0);
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 status");
        rd(8'h04, 32'h0, "R1 control");
        rd(8'h08, 32'h0, "R1 period lo");
        rd(8'h0C, 32'h0, "R1 period hi");
        rd(8'h10, 32'h0, "R1 snap lo");
        chk("R1 irq", {31'd0, irq}, 32'd0);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h0000_FFFF, "R1 count lo");
        rd(8'h14, 32'h0000_FFFF, "R1 count hi");
        // R2 undefined offsets
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0, "R2 undefined read");
        rd(8'h04, 32'h0, "R2 control untouched");
        rd(8'h00, 32'h0, "R2 status untouched");
        // R3 and R4: start and stop in one write
        wr(8'h04, 32'h0000_000F);
        rd(8'h04, 32'h3, "R3 control readback");
        rd(8'h00, 32'h0, "R4 start+stop stopped");
        wr(8'h04, 32'h0);
        // R8 period load, upper data bits dropped, byte lane bits ignored
        wr(8'h09, 32'h0001_0003);
        wr(8'h0C, 32'h0);
        rd(8'h08, 32'h3, "R8 period lo");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h3, "R8 count loaded");
        // R4 start one-shot, R5 counting
        wr(8'h04, 32'h4);
        rd(8'h00, 32'h2, "R4 running");
        ticks(2);
        wr(8'h14, 32'h0);
        rd(8'h10, 32'h1, "R5 count after two ticks");
        rd(8'h14, 32'h0, "R9 snap hi");
        ticks(1);
        rd(8'h00, 32'h2, "R6 no expiry at zero");
        ticks(1);
        rd(8'h00, 32'h1, "R6 R7 one-shot expiry");
        ticks(3);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h3, "R7 count held at period");
        // R10 clear, R11 enable
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h0, "R10 status cleared");
        wr(8'h04, 32'h1);
        chk("R11 no timeout", {31'd0, irq}, 32'd0);
        // R7 continuous
        wr(8'h04, 32'h7);
        ticks(4);
        rd(8'h00, 32'h3, "R7 continuous still running");
        chk("R11 irq asserted", {31'd0, irq}, 32'd1);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h3, "R6 reloaded");
        ticks(1);
        wr(8'h04, 32'h2);
        chk("R11 enable off", {31'd0, irq}, 32'd0);
        wr(8'h04, 32'h3);
        chk("R11 enable on", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R10 clear any data", {31'd0, irq}, 32'd0);
        // R8 period write while running
        wr(8'h0C, 32'h0001);
        rd(8'h00, 32'h0, "R8 write stops timer");
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h3, "R9 snap lo");
        rd(8'h14, 32'h1, "R9 snap hi");
        // R10 clear colliding with expiry
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h1);
        wr(8'h04, 32'h7);
        ticks(1);
        step(1'b1, 8'h00, 32'h0, 1'b1);
        rd(8'h00, 32'h3, "R10 expiry wins clear");
        // R4 stop, R5 hold while stopped
        wr(8'h04, 32'hB);
        rd(8'h00, 32'h1, "R4 stopped");
        ticks(5);
        wr(8'h10, 32'h0);
        rd(8'h10, 32'h1, "R5 held while stopped");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule